// File: doc/BRIEF.md
# Age-Ranked Fully Associative Address Translation Buffer

This block translates 16-bit virtual addresses into 16-bit physical addresses through eight fully associative entries. Pages are 256 bytes: the upper byte of an address is the page number and the lower byte passes through unchanged. Each entry carries a virtual page number, a physical frame number, a valid flag, a dirty flag and a three-bit recency rank. Rank 0 marks the most recently used entry, and invalid entries sit at rank 7.

A request is one cycle of `req_valid` with an address and a write flag. One cycle later the block reports whether it hit, the physical address, and an error flag. When no entry matches, the block takes the oldest frame from a small pool of free physical frames and installs the new mapping. It places that mapping in the lowest-numbered invalid entry, or in the valid entry ranked 7 when every entry is in use. The answer carries the new frame. A configuration port preloads entries and appends frames to the pool. An inspection port shows any entry's contents without side effects.

Top module: `tlb_age_lru`

## Requirements
- R1: After reset every entry is invalid with rank 7, dirty 0, page 0 and frame 0, the frame pool is empty and `resp_valid` is 0.
- R2: Every request produces `resp_valid` exactly one cycle later. On a hit or a filled miss, `resp_paddr` is the frame number (bits 15:8) concatenated with the request's unchanged offset (bits 7:0).
- R3: A request hits when a valid entry's page number equals address bits 15:8. A write hit sets that entry's dirty flag. A read hit leaves the dirty flag as it was.
- R4: On every hit or filled miss, the touched entry's rank becomes 0. Each other valid entry whose rank was below the touched entry's previous rank goes up by one. All other ranks stay unchanged, and invalid entries keep their rank.
- R5: On a miss the frame at the head of the pool is used, in the order the frames were appended. The new entry gets the request's page number and that frame, is valid, has dirty equal to the write flag, and `resp_hit` is 0.
- R6: A miss fills the lowest-indexed invalid entry. When all entries are valid, it replaces the entry whose rank is 7.
- R7: A miss while the pool is empty sets `resp_err` to 1 with `resp_hit` 0 and leaves every entry and the pool unchanged.
- R8: With `cfg_entry_we` high and no request, all fields of entry `cfg_idx` are written from the `cfg_*` inputs. In a cycle that also carries a request, the configuration write is ignored.
- R9: `cfg_pool_push` appends `cfg_pool_frame` to the pool, which holds four frames. A push to a full pool is dropped.
- R10: The inspection outputs show, without delay, the stored fields of entry `ins_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request this cycle |
| req_vaddr | input | 16 | Virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| resp_valid | output | 1 | Response for the request of the previous cycle |
| resp_hit | output | 1 | Request matched an existing entry |
| resp_err | output | 1 | Miss with no free frame available |
| resp_paddr | output | 16 | Translated physical address |
| cfg_entry_we | input | 1 | Write one entry from the cfg fields |
| cfg_idx | input | 3 | Entry to write |
| cfg_vpn | input | 8 | Page number to write |
| cfg_ppn | input | 8 | Frame number to write |
| cfg_valid | input | 1 | Valid flag to write |
| cfg_dirty | input | 1 | Dirty flag to write |
| cfg_age | input | 3 | Rank to write |
| cfg_pool_push | input | 1 | Append a frame to the free pool |
| cfg_pool_frame | input | 8 | Frame to append |
| ins_idx | input | 3 | Entry to inspect |
| ins_vpn | output | 8 | Inspected page number |
| ins_ppn | output | 8 | Inspected frame number |
| ins_valid | output | 1 | Inspected valid flag |
| ins_dirty | output | 1 | Inspected dirty flag |
| ins_age | output | 3 | Inspected rank |

## Verification
Each response is registered. A request presented before a rising edge is answered after that same edge: one cycle of latency, with the entry and rank updates visible on the inspection port at the same point. The bench drives every input on the falling edge, lets exactly one rising edge pass, and samples the response and the inspection outputs one time unit later. The inspection outputs are combinational, so after changing `ins_idx` the bench reads them after a short settle and never across a clock edge. The tests replay a known eight-entry sequence of mixed hits, fills and a replacement, and check every intermediate rank against hand-computed values.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W     = 16;
    localparam int OFF_W    = 8;
    localparam int VPN_W    = VA_W - OFF_W;
    localparam int PPN_W    = 8;
    localparam int PA_W     = PPN_W + OFF_W;
    localparam int ENTRIES  = 8;
    localparam int IDX_W    = $clog2(ENTRIES);
    localparam int AGE_W    = $clog2(ENTRIES);
    localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(ENTRIES - 1);

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic             valid;
        logic             dirty;
        logic [AGE_W-1:0] age;
    } tlb_entry_t;

    typedef tlb_entry_t [ENTRIES-1:0] tlb_table_t;
    typedef logic [ENTRIES-1:0][AGE_W-1:0] age_vec_t;
endpackage

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_pkg::*;
(
    input  tlb_table_t       table_i,
    input  logic [VPN_W-1:0] vpn_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] hit_idx_o,
    output logic             has_free_o,
    output logic [IDX_W-1:0] free_idx_o,
    output logic [IDX_W-1:0] oldest_idx_o
);
    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] free_vec;
    logic [ENTRIES-1:0] oldest_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g]  = table_i[g].valid && (table_i[g].vpn == vpn_i);
        assign free_vec[g]   = !table_i[g].valid;
        assign oldest_vec[g] = table_i[g].valid && (table_i[g].age == AGE_OLDEST);
    end

    always_comb begin
        hit_o        = |match_vec;
        has_free_o   = |free_vec;
        hit_idx_o    = '0;
        free_idx_o   = '0;
        oldest_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i])  hit_idx_o    = IDX_W'(i);
            if (free_vec[i])   free_idx_o   = IDX_W'(i);
            if (oldest_vec[i]) oldest_idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_age_update.sv
module tlb_age_update
    import tlb_pkg::*;
(
    input  tlb_table_t       table_i,
    input  logic [IDX_W-1:0] touch_idx_i,
    output age_vec_t         age_o
);
    logic [AGE_W-1:0] touch_old_age;

    assign touch_old_age = table_i[touch_idx_i].age;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_rank
        always_comb begin
            if (touch_idx_i == IDX_W'(g)) begin
                age_o[g] = '0;
            end else if (table_i[g].valid && (table_i[g].age < touch_old_age)) begin
                age_o[g] = table_i[g].age + AGE_W'(1);
            end else begin
                age_o[g] = table_i[g].age;
            end
        end
    end
endmodule

// File: rtl/tlb_frame_pool.sv
module tlb_frame_pool
    import tlb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [PPN_W-1:0] frame_i,
    input  logic             pop_i,
    output logic [PPN_W-1:0] head_o,
    output logic             empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][PPN_W-1:0] slot;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } pool_state_t;

    pool_state_t pool_q, pool_d;
    logic        full;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty_o = (pool_q.cnt == '0);
    assign full    = (pool_q.cnt == CNT_W'(DEPTH));
    assign head_o  = pool_q.slot[pool_q.rd];

    always_comb begin
        pool_d = pool_q;
        if (push_i && !full) begin
            pool_d.slot[pool_q.wr] = frame_i;
            pool_d.wr              = ptr_next(pool_q.wr);
        end
        if (pop_i && !empty_o) begin
            pool_d.rd = ptr_next(pool_q.rd);
        end
        pool_d.cnt = pool_q.cnt + CNT_W'(push_i && !full) - CNT_W'(pop_i && !empty_o);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pool_q <= '0;
        else        pool_q <= pool_d;
    end

    assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pool_q.cnt <= CNT_W'(DEPTH));

    assert_full_push_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && !pop_i) |=> (pool_q.cnt == CNT_W'(DEPTH)) && $stable(pool_q.wr));
endmodule

// File: rtl/tlb_age_lru.sv
module tlb_age_lru
    import tlb_pkg::*;
#(
    parameter int POOL_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic             resp_err,
    output logic [PA_W-1:0]  resp_paddr,
    input  logic             cfg_entry_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [VPN_W-1:0] cfg_vpn,
    input  logic [PPN_W-1:0] cfg_ppn,
    input  logic             cfg_valid,
    input  logic             cfg_dirty,
    input  logic [AGE_W-1:0] cfg_age,
    input  logic             cfg_pool_push,
    input  logic [PPN_W-1:0] cfg_pool_frame,
    input  logic [IDX_W-1:0] ins_idx,
    output logic [VPN_W-1:0] ins_vpn,
    output logic [PPN_W-1:0] ins_ppn,
    output logic             ins_valid,
    output logic             ins_dirty,
    output logic [AGE_W-1:0] ins_age
);
    typedef struct packed {
        tlb_table_t      entries;
        logic            resp_valid;
        logic            resp_hit;
        logic            resp_err;
        logic [PA_W-1:0] resp_paddr;
    } core_state_t;

    core_state_t st_q, st_d;

    logic [VPN_W-1:0] req_vpn;
    logic [OFF_W-1:0] req_off;
    logic             lk_hit, lk_has_free;
    logic [IDX_W-1:0] lk_hit_idx, lk_free_idx, lk_oldest_idx;
    logic [IDX_W-1:0] touch_idx;
    age_vec_t         next_age;
    logic             pool_pop, pool_empty;
    logic [PPN_W-1:0] pool_head;
    logic             miss_err;

    assign req_vpn = req_vaddr[VA_W-1:OFF_W];
    assign req_off = req_vaddr[OFF_W-1:0];

    tlb_lookup u_lookup (
        .table_i      (st_q.entries),
        .vpn_i        (req_vpn),
        .hit_o        (lk_hit),
        .hit_idx_o    (lk_hit_idx),
        .has_free_o   (lk_has_free),
        .free_idx_o   (lk_free_idx),
        .oldest_idx_o (lk_oldest_idx)
    );

    assign touch_idx = lk_hit      ? lk_hit_idx  :
                       lk_has_free ? lk_free_idx : lk_oldest_idx;

    tlb_age_update u_age (
        .table_i     (st_q.entries),
        .touch_idx_i (touch_idx),
        .age_o       (next_age)
    );

    tlb_frame_pool #(.DEPTH(POOL_DEPTH)) u_pool (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (cfg_pool_push),
        .frame_i (cfg_pool_frame),
        .pop_i   (pool_pop),
        .head_o  (pool_head),
        .empty_o (pool_empty)
    );

    assign miss_err = req_valid && !lk_hit && pool_empty;

    always_comb begin
        st_d            = st_q;
        st_d.resp_valid = req_valid;
        st_d.resp_hit   = 1'b0;
        st_d.resp_err   = 1'b0;
        st_d.resp_paddr = '0;
        pool_pop        = 1'b0;
        if (req_valid) begin
            if (miss_err) begin
                st_d.resp_err = 1'b1;
            end else begin
                for (int i = 0; i < ENTRIES; i++) begin
                    st_d.entries[i].age = next_age[i];
                end
                if (lk_hit) begin
                    st_d.resp_hit   = 1'b1;
                    st_d.resp_paddr = {st_q.entries[touch_idx].ppn, req_off};
                    if (req_write) st_d.entries[touch_idx].dirty = 1'b1;
                end else begin
                    pool_pop                       = 1'b1;
                    st_d.entries[touch_idx].vpn    = req_vpn;
                    st_d.entries[touch_idx].ppn    = pool_head;
                    st_d.entries[touch_idx].valid  = 1'b1;
                    st_d.entries[touch_idx].dirty  = req_write;
                    st_d.entries[touch_idx].age    = '0;
                    st_d.resp_paddr                = {pool_head, req_off};
                end
            end
        end else if (cfg_entry_we) begin
            st_d.entries[cfg_idx].vpn   = cfg_vpn;
            st_d.entries[cfg_idx].ppn   = cfg_ppn;
            st_d.entries[cfg_idx].valid = cfg_valid;
            st_d.entries[cfg_idx].dirty = cfg_dirty;
            st_d.entries[cfg_idx].age   = cfg_age;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                st_q.entries[i].age <= AGE_OLDEST;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid = st_q.resp_valid;
    assign resp_hit   = st_q.resp_hit;
    assign resp_err   = st_q.resp_err;
    assign resp_paddr = st_q.resp_paddr;

    assign ins_vpn   = st_q.entries[ins_idx].vpn;
    assign ins_ppn   = st_q.entries[ins_idx].ppn;
    assign ins_valid = st_q.entries[ins_idx].valid;
    assign ins_dirty = st_q.entries[ins_idx].dirty;
    assign ins_age   = st_q.entries[ins_idx].age;

    logic [IDX_W:0] mru_count;
    always_comb begin
        mru_count = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            mru_count = mru_count + (IDX_W+1)'(st_q.entries[i].valid && st_q.entries[i].age == '0);
        end
    end

    assert_one_cycle_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    assert_offset_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !miss_err) |=> resp_paddr[OFF_W-1:0] == $past(req_off));

    assert_write_sets_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !miss_err) |=> st_q.entries[$past(touch_idx)].dirty);

    assert_single_mru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !miss_err) |=> mru_count == (IDX_W+1)'(1));

    assert_err_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        miss_err |=> resp_err && !resp_hit && (st_q.entries == $past(st_q.entries)));
endmodule

// File: tb/tlb_age_lru_test.sv
module tlb_age_lru_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        resp_valid, resp_hit, resp_err;
    logic [15:0] resp_paddr;
    logic        cfg_entry_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [7:0]  cfg_vpn = '0, cfg_ppn = '0;
    logic        cfg_valid = 1'b0, cfg_dirty = 1'b0;
    logic [2:0]  cfg_age = '0;
    logic        cfg_pool_push = 1'b0;
    logic [7:0]  cfg_pool_frame = '0;
    logic [2:0]  ins_idx = '0;
    logic [7:0]  ins_vpn, ins_ppn;
    logic        ins_valid, ins_dirty;
    logic [2:0]  ins_age;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_age_lru uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_err(resp_err), .resp_paddr(resp_paddr),
        .cfg_entry_we(cfg_entry_we), .cfg_idx(cfg_idx), .cfg_vpn(cfg_vpn), .cfg_ppn(cfg_ppn),
        .cfg_valid(cfg_valid), .cfg_dirty(cfg_dirty), .cfg_age(cfg_age),
        .cfg_pool_push(cfg_pool_push), .cfg_pool_frame(cfg_pool_frame),
        .ins_idx(ins_idx), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
        .ins_valid(ins_valid), .ins_dirty(ins_dirty), .ins_age(ins_age)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_entry(input logic [2:0] idx, input logic [7:0] vpn, input logic [7:0] ppn,
                             input logic v, input logic d, input logic [2:0] age);
        @(negedge clk);
        cfg_entry_we = 1'b1; cfg_idx = idx; cfg_vpn = vpn; cfg_ppn = ppn;
        cfg_valid = v; cfg_dirty = d; cfg_age = age;
        @(negedge clk);
        cfg_entry_we = 1'b0;
    endtask

    task automatic push_frame(input logic [7:0] f);
        @(negedge clk);
        cfg_pool_push = 1'b1; cfg_pool_frame = f;
        @(negedge clk);
        cfg_pool_push = 1'b0;
    endtask

    // Request at a falling edge, response sampled 1 unit after the next rising edge (R2)
    task automatic access(input logic [15:0] va, input logic wr, input logic exp_hit,
                          input logic exp_err, input logic [15:0] exp_pa, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        check(32'(resp_valid), 32'd1, {tag, " R2 resp_valid"});
        check(32'(resp_hit), 32'(exp_hit), {tag, " resp_hit"});
        check(32'(resp_err), 32'(exp_err), {tag, " resp_err"});
        if (!exp_err) check(32'(resp_paddr), 32'(exp_pa), {tag, " R2 resp_paddr"});
    endtask

    // Inspection port read (R10)
    task automatic inspect(input logic [2:0] idx, input logic [7:0] vpn, input logic [7:0] ppn,
                           input logic v, input logic d, input logic [2:0] age, input string tag);
        ins_idx = idx;
        #1;
        check(32'(ins_vpn), 32'(vpn), {tag, " R10 vpn"});
        check(32'(ins_ppn), 32'(ppn), {tag, " R10 ppn"});
        check(32'(ins_valid), 32'(v), {tag, " valid"});
        check(32'(ins_dirty), 32'(d), {tag, " dirty"});
        check(32'(ins_age), 32'(age), {tag, " age"});
    endtask

    task automatic check_ages(input logic [2:0] a0, a1, a2, a3, a4, a5, a6, a7, input string tag);
        logic [2:0] exp [8];
        exp = '{a0, a1, a2, a3, a4, a5, a6, a7};
        for (int i = 0; i < 8; i++) begin
            ins_idx = 3'(i);
            #1;
            check(32'(ins_age), 32'(exp[i]), $sformatf("%s R4 age of entry %0d", tag, i));
        end
    endtask

    task automatic test_reset_state();
        do_reset();
        #1;
        check(32'(resp_valid), 32'd0, "R1 resp_valid after reset");
        for (int i = 0; i < 8; i++) inspect(3'(i), 8'h00, 8'h00, 1'b0, 1'b0, 3'd7, "R1 reset entry");
        access(16'h1234, 1'b0, 1'b0, 1'b1, 16'h0, "R1 empty pool after reset");
    endtask

    task automatic test_translation_sequence();
        cfg_entry(3'd0, 8'h01, 8'h11, 1'b1, 1'b1, 3'd0);
        cfg_entry(3'd1, 8'h00, 8'h00, 1'b0, 1'b0, 3'd7);
        cfg_entry(3'd2, 8'h10, 8'h13, 1'b1, 1'b1, 3'd1);
        cfg_entry(3'd3, 8'h20, 8'h12, 1'b1, 1'b0, 3'd5);
        cfg_entry(3'd4, 8'h00, 8'h00, 1'b0, 1'b0, 3'd7);
        cfg_entry(3'd5, 8'h11, 8'h14, 1'b1, 1'b0, 3'd4);
        cfg_entry(3'd6, 8'hAC, 8'h15, 1'b1, 1'b1, 3'd2);
        cfg_entry(3'd7, 8'hFF, 8'hFF, 1'b1, 1'b0, 3'd3);
        inspect(3'd3, 8'h20, 8'h12, 1'b1, 1'b0, 3'd5, "R8 config write");
        push_frame(8'h17);
        push_frame(8'h18);
        push_frame(8'h19);
        access(16'h11F0, 1'b0, 1'b1, 1'b0, 16'h14F0, "R3 read hit");
        inspect(3'd5, 8'h11, 8'h14, 1'b1, 1'b0, 3'd0, "R3 read hit keeps dirty");
        check_ages(3'd1, 3'd7, 3'd2, 3'd5, 3'd7, 3'd0, 3'd3, 3'd4, "after read hit");
        access(16'h1301, 1'b1, 1'b0, 1'b0, 16'h1701, "R5 first fill");
        inspect(3'd1, 8'h13, 8'h17, 1'b1, 1'b1, 3'd0, "R6 lowest invalid filled");
        check_ages(3'd2, 3'd0, 3'd3, 3'd6, 3'd7, 3'd1, 3'd4, 3'd5, "after fill");
        access(16'h20AE, 1'b1, 1'b1, 1'b0, 16'h12AE, "R3 write hit");
        inspect(3'd3, 8'h20, 8'h12, 1'b1, 1'b1, 3'd0, "R3 write hit sets dirty");
        check_ages(3'd3, 3'd1, 3'd4, 3'd0, 3'd7, 3'd2, 3'd5, 3'd6, "after write hit");
        access(16'h2332, 1'b1, 1'b0, 1'b0, 16'h1832, "R5 second fill");
        inspect(3'd4, 8'h23, 8'h18, 1'b1, 1'b1, 3'd0, "R6 next invalid filled");
        access(16'h20FF, 1'b0, 1'b1, 1'b0, 16'h12FF, "R3 read hit again");
        check_ages(3'd4, 3'd2, 3'd5, 3'd0, 3'd1, 3'd3, 3'd6, 3'd7, "after near-MRU hit");
        access(16'h3415, 1'b1, 1'b0, 1'b0, 16'h1915, "R5 third fill");
        inspect(3'd7, 8'h34, 8'h19, 1'b1, 1'b1, 3'd0, "R6 rank-7 entry replaced");
        check_ages(3'd5, 3'd3, 3'd6, 3'd1, 3'd2, 3'd4, 3'd7, 3'd0, "after replacement");
        inspect(3'd5, 8'h11, 8'h14, 1'b1, 1'b0, 3'd4, "R3 final clean entry");
    endtask

    task automatic test_empty_pool_error();
        access(16'h5500, 1'b1, 1'b0, 1'b1, 16'h0, "R7 miss with empty pool");
        inspect(3'd7, 8'h34, 8'h19, 1'b1, 1'b1, 3'd0, "R7 state frozen");
        check_ages(3'd5, 3'd3, 3'd6, 3'd1, 3'd2, 3'd4, 3'd7, 3'd0, "R7 ranks frozen");
    endtask

    task automatic test_cfg_during_request();
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 16'h0142; req_write = 1'b0;
        cfg_entry_we = 1'b1; cfg_idx = 3'd5; cfg_vpn = 8'h77; cfg_ppn = 8'h66;
        cfg_valid = 1'b0; cfg_dirty = 1'b1; cfg_age = 3'd1;
        @(posedge clk);
        #1;
        req_valid = 1'b0; cfg_entry_we = 1'b0;
        check(32'(resp_hit), 32'd1, "R8 concurrent request served");
        check(32'(resp_paddr), 32'h1142, "R8 concurrent request paddr");
        inspect(3'd5, 8'h11, 8'h14, 1'b1, 1'b0, 3'd5, "R8 config ignored during request");
    endtask

    task automatic test_pool_full();
        do_reset();
        for (int k = 0; k < 5; k++) push_frame(8'h40 + 8'(k));
        for (int k = 0; k < 4; k++)
            access({8'(k + 1), 8'h0C}, 1'b0, 1'b0, 1'b0, {8'h40 + 8'(k), 8'h0C}, "R9 pool order");
        access(16'h0500, 1'b0, 1'b0, 1'b1, 16'h0, "R9 fifth push dropped");
        inspect(3'd4, 8'h00, 8'h00, 1'b0, 1'b0, 3'd7, "R9 no fill after drop");
        inspect(3'd0, 8'h01, 8'h40, 1'b1, 1'b0, 3'd3, "R4 first fill aged");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset_state();
        test_translation_sequence();
        test_empty_pool_error();
        test_cfg_during_request();
        test_pool_full();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule